// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM bit stream into parallel sample words. The stream is timed by an external master: a bit clock, a channel-select (word) clock and a data line. The block samples those three lines with a faster system clock. It detects edges of the bit clock and takes one data bit on each chosen edge. It sorts the bits into left and right words and, at each subframe boundary, presents the finished word with a one-cycle strobe and a channel flag.

Two framings are handled by the same logic. In I2S framing the most significant bit follows the channel-clock change by one bit period, bits are taken on the rising bit-clock edge, and a low channel clock marks the left channel. In left-justified framing the most significant bit is on the first bit clock after the change, a high channel clock marks the left channel, and bits can be taken on either bit-clock edge. The word width can be set up to 24 bits. A compressed-data mode forces 16-bit words. The configuration is held in a register that loads only while the enable input is low.

Top module: `serial_audio_rx`

## Requirements
- R1: Data arrives most significant bit first. Each finished word is presented right-aligned on `word_out`, in the width that is in force, with its upper bits zero.
- R2: With `cfg_lj`=0 (I2S), the bit taken on the first rising bit-clock edge after a channel-clock change still belongs to the previous word. The new word's most significant bit is taken on the following rising edge.
- R3: With `cfg_lj`=0, a word received while the channel clock was low is flagged `word_right`=0 (left), and one received while it was high is flagged `word_right`=1.
- R4: With `cfg_lj`=1 (left-justified), the bit taken on the first capture edge after a channel-clock change is the new word's most significant bit.
- R5: With `cfg_lj`=1, a high channel clock means left (`word_right`=0) and a low channel clock means right (`word_right`=1).
- R6: With `cfg_lj`=1 and `cfg_fall`=1, bits are taken on the falling bit-clock edge. Otherwise they are taken on the rising edge. `cfg_fall` has no effect with `cfg_lj`=0.
- R7: `cfg_width` sets the word width from 1 to 24 bits. A value of 0 or above 24 selects 24.
- R8: With `cfg_cmp`=1 the word width is 16 bits, whatever the value of `cfg_width`.
- R9: Bits of a subframe that come after the word width is reached are ignored.
- R10: If a subframe carries fewer bits than the word width, the word is zero-filled at its least significant end.
- R11: `word_valid` is high for exactly one system cycle per word. After `en` rises, the partial subframe in progress and the subframe boundary that ends it produce no word.
- R12: Configuration inputs are loaded only while `en` is low. Changes while `en` is high have no effect. While `en` is low, no word is produced.
- R13: A synchronous reset (`rst_n` low) clears `word_valid`, `word_out` and `word_right` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Receive enable; configuration loads while low |
| cfg_lj | input | 1 | 0 = I2S framing, 1 = left-justified framing |
| cfg_fall | input | 1 | Left-justified only: take bits on falling bit-clock edge |
| cfg_cmp | input | 1 | Compressed mode, fixed 16-bit words |
| cfg_width | input | 5 | PCM word width in bits (0 or >24 means 24) |
| sclk_in | input | 1 | Serial bit clock from the external master |
| lrclk_in | input | 1 | Channel-select clock from the external master |
| sdata_in | input | 1 | Serial data |
| word_out | output | 24 | Received word, right-aligned |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_right | output | 1 | Channel flag of the word: 0 left, 1 right |

## Verification
If the bit counter or the accumulator goes wrong, the next word shows it at `word_out`: its bits are shifted, truncated or padded wrongly, and this is visible within one subframe of the fault. If the stored channel level is wrong, either `word_right` flips or a boundary is missed. A missed boundary makes a word vanish or two words merge, and the count of strobes per stereo pair shows this at once. A wrong configuration latch shows up when mode inputs are changed in the middle of a stream. The words that follow then come out in the new width or framing instead of the one loaded while disabled.

// File: rtl/sarx_pkg.sv
// Shared types for the serial audio receiver.
package sarx_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;
endpackage

// File: rtl/sarx_sync.sv
// Two-flop synchronizer bank for N asynchronous single-bit inputs.
// Assumes each input is stable for at least two system clocks between changes.
module sarx_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta;
        logic stab;
        // two register stages per input bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= din[i];
                stab <= meta;
            end
        end
        assign dout[i] = stab;
    end
endmodule

// File: rtl/sarx_cfg.sv
// Configuration holder: loads framing, edge and width while en is low and
// freezes them while en is high. The effective width is resolved here.
module sarx_cfg
    import sarx_pkg::*;
#(
    parameter int WMAX  = 24,
    parameter int CMP_W = 16,
    parameter int WW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          lj_in,
    input  logic          fall_in,
    input  logic          cmp_in,
    input  logic [WW-1:0] width_in,
    output fmt_e          fmt,
    output logic          fall,
    output logic [WW-1:0] weff
);
    logic [WW-1:0] weff_nxt;

    // resolve requested width: compressed forces CMP_W, out-of-range gives WMAX
    always_comb begin
        if (cmp_in)
            weff_nxt = WW'(CMP_W);
        else if (width_in == '0 || width_in > WW'(WMAX))
            weff_nxt = WW'(WMAX);
        else
            weff_nxt = width_in;
    end

    // load configuration only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt  <= FMT_I2S;
            fall <= 1'b0;
            weff <= WW'(WMAX);
        end else if (!en) begin
            fmt  <= fmt_e'(lj_in);
            fall <= lj_in & fall_in;
            weff <= weff_nxt;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable({fmt, fall, weff})) else $error("cfg changed while enabled"); // R12
    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (weff != '0 && weff <= WW'(WMAX))) else $error("width out of range"); // R7
endmodule

// File: rtl/sarx_deser.sv
// Deserializer: finds capture edges of the synchronized bit clock, collects
// bits MSB first into a left-aligned accumulator and emits a word at each
// channel-clock boundary. Assumes system clock >= 4x bit clock.
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int WMAX = 24,
    parameter int WW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  fmt_e            fmt,
    input  logic            fall,
    input  logic [WW-1:0]   weff,
    input  logic            sclk_s,
    input  logic            lr_s,
    input  logic            sd_s,
    output logic [WMAX-1:0] word,
    output logic            valid,
    output logic            right
);
    logic            sclk_d;
    logic            cap;
    logic            seen;
    logic            armed;
    logic            lr_prev;
    logic            bound;
    logic [WW-1:0]   cnt;
    logic [WW-1:0]   cnt_app;
    logic [WMAX-1:0] acc;
    logic [WMAX-1:0] acc_app;
    logic [WMAX-1:0] emit_src;
    logic [WW-1:0]   shamt;

    // previous bit-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // capture edge: falling only in left-justified mode with fall set
    always_comb begin
        if (fmt == FMT_LJ && fall) cap = ~sclk_s & sclk_d;
        else                       cap = sclk_s & ~sclk_d;
    end

    // accumulator with the current bit appended, until width reached
    always_comb begin
        acc_app = acc;
        cnt_app = cnt;
        if (cnt < weff) begin
            acc_app[WMAX-1-int'(cnt)] = sd_s;
            cnt_app = cnt + 1'b1;
        end
    end

    // boundary detection and emitted word source per framing
    assign bound    = seen && (lr_s != lr_prev);
    assign emit_src = (fmt == FMT_I2S) ? acc_app : acc;
    assign shamt    = WW'(WMAX) - weff;

    // bit collection, boundary handling and word output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            armed   <= 1'b0;
            lr_prev <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            valid   <= 1'b0;
            word    <= '0;
            right   <= 1'b0;
        end else if (!en) begin
            seen    <= 1'b0;
            armed   <= 1'b0;
            lr_prev <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (cap) begin
                seen    <= 1'b1;
                lr_prev <= lr_s;
                if (bound) begin
                    armed <= 1'b1;
                    if (armed) begin
                        valid <= 1'b1;
                        word  <= emit_src >> shamt;
                        right <= (fmt == FMT_I2S) ? lr_prev : ~lr_prev;
                    end
                    if (fmt == FMT_I2S) begin
                        acc <= '0;
                        cnt <= '0;
                    end else begin
                        acc <= {sd_s, {(WMAX-1){1'b0}}};
                        cnt <= WW'(1);
                    end
                end else begin
                    acc <= acc_app;
                    cnt <= cnt_app;
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid) else $error("valid longer than one cycle"); // R11
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid) else $error("word while disabled"); // R12
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= weff)) else $error("bit count beyond width"); // R9
endmodule

// File: rtl/serial_audio_rx.sv
// Top of the multi-format serial audio receiver. Synchronizes the serial
// lines, holds the configuration and deserializes words.
// Assumes clk is at least 4x sclk_in; configuration changes need en low.
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int WMAX  = 24,
    parameter int CMP_W = 16,
    localparam int WW   = $clog2(WMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cfg_lj,
    input  logic            cfg_fall,
    input  logic            cfg_cmp,
    input  logic [WW-1:0]   cfg_width,
    input  logic            sclk_in,
    input  logic            lrclk_in,
    input  logic            sdata_in,
    output logic [WMAX-1:0] word_out,
    output logic            word_valid,
    output logic            word_right
);
    logic [2:0]    lines_s;
    fmt_e          fmt;
    logic          fall;
    logic [WW-1:0] weff;

    sarx_sync #(.N(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdata_in, lrclk_in, sclk_in}),
        .dout  (lines_s)
    );

    sarx_cfg #(.WMAX(WMAX), .CMP_W(CMP_W), .WW(WW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .lj_in    (cfg_lj),
        .fall_in  (cfg_fall),
        .cmp_in   (cfg_cmp),
        .width_in (cfg_width),
        .fmt      (fmt),
        .fall     (fall),
        .weff     (weff)
    );

    sarx_deser #(.WMAX(WMAX), .WW(WW)) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .fmt    (fmt),
        .fall   (fall),
        .weff   (weff),
        .sclk_s (lines_s[0]),
        .lr_s   (lines_s[1]),
        .sd_s   (lines_s[2]),
        .word   (word_out),
        .valid  (word_valid),
        .right  (word_right)
    );
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_lj = 1'b0, cfg_fall = 1'b0, cfg_cmp = 1'b0;
    logic [4:0]  cfg_width = 5'd24;
    logic        sclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
    logic [23:0] word_out;
    logic        word_valid, word_right;

    int total = 0;
    int bad = 0;
    int pulse_bad = 0;
    int ncap = 0;
    logic [24:0] cap_q [4];
    logic        pv = 1'b0;
    bit          tamper = 1'b0;

    always #2 clk = ~clk;

    serial_audio_rx u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_lj(cfg_lj), .cfg_fall(cfg_fall),
        .cfg_cmp(cfg_cmp), .cfg_width(cfg_width), .sclk_in(sclk_in),
        .lrclk_in(lrclk_in), .sdata_in(sdata_in), .word_out(word_out),
        .word_valid(word_valid), .word_right(word_right)
    );

    // {lj, fall, cmp, width[5], slots[6], txbits[5], left[24], right[24]}
    localparam logic [66:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b0, 5'd24, 6'd32, 5'd24, 24'hA5C3E1, 24'h1E2D3C},
        {1'b0, 1'b0, 1'b0, 5'd16, 6'd32, 5'd24, 24'h123456, 24'hFEDCBA},
        {1'b0, 1'b0, 1'b0, 5'd24, 6'd16, 5'd16, 24'h00BEEF, 24'h000F0F},
        {1'b1, 1'b0, 1'b0, 5'd24, 6'd32, 5'd24, 24'h9A8B7C, 24'h6D5E4F},
        {1'b1, 1'b1, 1'b0, 5'd24, 6'd32, 5'd24, 24'h13579B, 24'h2468AC},
        {1'b1, 1'b1, 1'b0, 5'd20, 6'd24, 5'd20, 24'h0ABCDE, 24'h012345},
        {1'b0, 1'b0, 1'b1, 5'd24, 6'd32, 5'd24, 24'hC0FFEE, 24'h5A5A5A},
        {1'b1, 1'b0, 1'b0, 5'd0,  6'd32, 5'd24, 24'h800001, 24'h7FFFFE},
        {1'b1, 1'b0, 1'b1, 5'd8,  6'd16, 5'd16, 24'h008001, 24'h007FFE},
        {1'b0, 1'b0, 1'b0, 5'd1,  6'd24, 5'd24, 24'h800000, 24'h7FFFFF}
    };

    // collect words and watch strobe width away from the active edge
    always @(negedge clk) begin
        if (word_valid) begin
            if (ncap < 4) cap_q[ncap] = {word_right, word_out};
            ncap = ncap + 1;
            if (pv) pulse_bad = pulse_bad + 1;
        end
        pv = word_valid;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [23:0] w, input int txw, input int j);
        return (j < txw) ? w[txw-1-j] : 1'b0;
    endfunction

    function automatic int width_of(input logic cmp, input int w);
        if (cmp) return 16;
        if (w == 0 || w > 24) return 24;
        return w;
    endfunction

    function automatic logic [23:0] expect_word(input logic [23:0] w, input int txw, input int we);
        logic [47:0] t;
        t = 48'(w);
        if (txw >= we) t = t >> (txw - we);
        else           t = t << (we - txw);
        return 24'(t & ((48'd1 << we) - 48'd1));
    endfunction

    task automatic run_vec(input logic [66:0] v, input string tag);
        logic        lj, fl;
        int          nb, txw, we;
        logic [23:0] wds [4];
        logic [23:0] eL, eR;
        lj  = v[66];
        fl  = v[65];
        nb  = int'(v[58:53]);
        txw = int'(v[52:48]);
        we  = width_of(v[64], int'(v[63:59]));
        wds[0] = 24'hFFFFFF & ((24'd1 << txw) - 24'd1);
        wds[1] = v[47:24];
        wds[2] = v[23:0];
        wds[3] = 24'h0;
        @(negedge clk);
        en = 1'b0;
        cfg_lj = lj; cfg_fall = v[65]; cfg_cmp = v[64]; cfg_width = v[63:59];
        sclk_in = (lj && fl) ? 1'b0 : 1'b1;
        lrclk_in = lj ? 1'b0 : 1'b1;
        sdata_in = 1'b0;
        repeat (6) @(negedge clk);
        ncap = 0;
        en = 1'b1;
        repeat (6) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < nb; j++) begin
                logic lv, dv;
                if (tamper && s == 1 && j == 0) begin
                    cfg_width = 5'd8; cfg_lj = ~cfg_lj; cfg_cmp = 1'b1;
                end
                lv = lj ? (s % 2 == 1) : (s % 2 == 0);
                if (lj)          dv = bit_at(wds[s], txw, j);
                else if (j == 0) dv = (s == 0) ? 1'b0 : bit_at(wds[s-1], txw, nb - 1);
                else             dv = bit_at(wds[s], txw, j - 1);
                sclk_in = (lj && fl) ? 1'b1 : 1'b0;
                lrclk_in = lv;
                sdata_in = dv;
                repeat (4) @(negedge clk);
                sclk_in = ~sclk_in;
                repeat (4) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        eL = expect_word(wds[1], txw, we);
        eR = expect_word(wds[2], txw, we);
        chk(ncap == 2, {"R11 word count ", tag}, 32'(ncap), 32'd2);
        chk(cap_q[0] == {1'b0, eL}, {"R1 left word/flag ", tag}, 32'(cap_q[0]), 32'({1'b0, eL}));
        chk(cap_q[1] == {1'b1, eR}, {"R1 right word/flag ", tag}, 32'(cap_q[1]), 32'({1'b1, eR}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R13: reset state
        chk(word_valid == 1'b0, "R13 valid after reset", 32'(word_valid), 0);
        chk(word_out == 24'h0, "R13 word after reset", 32'(word_out), 0);
        chk(word_right == 1'b0, "R13 flag after reset", 32'(word_right), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 per entry
        for (int i = 0; i < 10; i++) run_vec(VEC[i], $sformatf("vec%0d R2-10", i));

        // R12: configuration changes while enabled are ignored
        tamper = 1'b1;
        run_vec(VEC[0], "R12 tamper");
        tamper = 1'b0;

        // R12: no words while disabled even with activity on the lines
        ncap = 0;
        for (int k = 0; k < 40; k++) begin
            sclk_in = ~sclk_in;
            if (k % 8 == 0) lrclk_in = ~lrclk_in;
            sdata_in = k[1];
            repeat (4) @(negedge clk);
        end
        chk(ncap == 0, "R12 quiet while disabled", 32'(ncap), 0);

        // R11: strobe was never wider than one cycle
        chk(pulse_bad == 0, "R11 strobe width", 32'(pulse_bad), 0);

        // R13: mid-run reset clears held word
        chk(word_out != 24'h0, "R13 word held before reset", 32'(word_out), 32'hFFFFFFFF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(word_out == 24'h0 && word_right == 1'b0 && word_valid == 1'b0,
            "R13 outputs cleared", 32'({word_valid, word_right, word_out}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule